// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes two-channel serial audio from one of two input ports and turns it into parallel 20-bit left and right samples. The host picks the port and the framing. There are two framings, each with two timings. In the MSB-first framing the word starts just after the word-select edge. In the end-aligned framing the word's last bit sits against the next word-select edge. Each framing has a normal timing and an alternative timing in which the word-select edge comes one bit clock later relative to the data. Four resolution codes are supported, and anything wider than 20 bits keeps only its top 20 bits.

The block runs entirely on its system clock, which is also the converter master clock. It oversamples the bit clock, word select and data. In slave mode the bit clock and word select come from the selected port. In master mode the block divides its clock down to a bit clock and word select, drives them out to the converter, and decodes the data against them. The divide ratio is 4 or 6, matching a 256x or 384x master clock. A frame is only reported once a complete left word and a complete right word have been captured, and the pair is flagged by a single-cycle strobe.

Top module: `audio_serial_rx`

## Requirements
- R1: Only the bit clock, word select and data of the port chosen by `cfg_port_sel` (0 or 1) affect the outputs; activity on the other port has no effect.
- R2: With `cfg_rj`=0 and `cfg_alt`=0, word select low marks the left word. The word's MSB is the data sampled at the second rising bit clock after the word-select change, and the bits follow MSB first.
- R3: With `cfg_alt`=1 the word-select change comes one bit clock later relative to the data. In the MSB-first framing the MSB is sampled at the first rising bit clock that sees the new word select. In the end-aligned framing the LSB is sampled two rising bit clocks before it.
- R4: With `cfg_rj`=1 and `cfg_alt`=0, the word's LSB is the data sampled at the last rising bit clock before the one that sees the new word select. The word fills the N bits that end there.
- R5: `cfg_res` selects N: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Words are placed MSB-aligned in the 20-bit outputs, and the bits below them are zero.
- R6: With a 24-bit word only its 20 most significant bits are kept. In the end-aligned framing code 3 behaves as 20 bits.
- R7: `sample_valid` is a single-cycle pulse raised when a right word completes. It carries that right word and the left word captured just before it. Both outputs hold their values between pulses.
- R8: After reset the outputs are zero. The slot in progress at reset is discarded, and no pulse appears until one left word and then one right word have been fully captured.
- R9: If the rising bit clock that completes a word is present on the pins (or on `bclk_out`) before clock edge k, the outputs and the pulse change at clock edge k+2.
- R10: In master mode `bclk_out` is the clock divided by 4 (`cfg_mclk384`=0) or by 6 (`cfg_mclk384`=1), with its high phase in the second half of each period. `ws_out` starts low, changes only together with a falling `bclk_out`, and changes after every 32 bit clocks, giving 64 bit clocks per frame.
- R11: In slave mode `bclk_out` and `ws_out` stay low.
- R12: In master mode decoding uses the block's own bit clock and word select, together with the data pin of the selected port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the converter master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_sel | input | 1 | Input port choice |
| cfg_master | input | 1 | 1: generate bit clock and word select |
| cfg_mclk384 | input | 1 | Master divide ratio: 0 gives /4, 1 gives /6 |
| cfg_rj | input | 1 | 1: end-aligned framing, 0: MSB-first framing |
| cfg_alt | input | 1 | 1: alternative word-select timing |
| cfg_res | input | 2 | Resolution code |
| bclk_in | input | 2 | Bit clock per port (slave mode) |
| ws_in | input | 2 | Word select per port (slave mode) |
| sd_in | input | 2 | Serial data per port |
| bclk_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated word select |
| left_out | output | 20 | Left sample |
| right_out | output | 20 | Right sample |
| sample_valid | output | 1 | Frame strobe |

## Verification
Every result of this block falls due two clock edges after the first clock edge that samples the completing rising bit clock on the pins. In terms of the bench's own samples, which it takes on the falling clock edge, that is three samples later.

The bench's behavioural decoder watches the same pins the design uses. Each time it finishes a frame it books the expected pulse and sample pair for exactly that sample. On every falling edge it then checks that the pulse is either present with the booked data or absent, so early, late, missing or extra pulses are all reported.

In master mode the bit-clock period and the spacing of word-select changes are measured on the outputs, one bit clock at a time.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  localparam int unsigned OUT_W = 20;
  localparam int unsigned NB_W  = 5;

  typedef struct packed {
    logic bclk;
    logic ws;
    logic sd;
  } serial_t;

  // resolution code to kept bit count (wider words are cut to OUT_W)
  function automatic logic [NB_W-1:0] kept_bits(input logic [1:0] code);
    case (code)
      2'd0:    return NB_W'(16);
      2'd1:    return NB_W'(18);
      default: return NB_W'(OUT_W);
    endcase
  endfunction
endpackage

// File: rtl/asrx_clkgen.sv
module asrx_clkgen #(
  parameter int unsigned DIV_LO     = 4,
  parameter int unsigned DIV_HI     = 6,
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel_hi,
  output logic bclk_o,
  output logic ws_o
);
  localparam int unsigned DIV_W = $clog2(DIV_HI);
  localparam int unsigned BC_W  = $clog2(FRAME_BITS);

  logic [DIV_W-1:0] mc_q, mc_d, last_cnt, half_cnt;
  logic [BC_W-1:0]  bc_q, bc_d;
  logic             bclk_q, bclk_d, ws_q, ws_d;

  always_comb begin
    last_cnt = sel_hi ? DIV_W'(DIV_HI - 1) : DIV_W'(DIV_LO - 1);
    half_cnt = sel_hi ? DIV_W'(DIV_HI / 2) : DIV_W'(DIV_LO / 2);
    mc_d     = mc_q;
    bc_d     = bc_q;
    bclk_d   = bclk_q;
    ws_d     = ws_q;
    if (!en) begin
      mc_d   = '0;
      bc_d   = '0;
      bclk_d = 1'b0;
      ws_d   = 1'b0;
    end else begin
      mc_d   = (mc_q >= last_cnt) ? '0 : mc_q + 1'b1;
      bclk_d = (mc_d >= half_cnt);
      if (mc_d == '0) begin
        bc_d = bc_q + 1'b1;
        ws_d = bc_d[BC_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= '0;
      bc_q   <= '0;
      bclk_q <= 1'b0;
      ws_q   <= 1'b0;
    end else begin
      mc_q   <= mc_d;
      bc_q   <= bc_d;
      bclk_q <= bclk_d;
      ws_q   <= ws_d;
    end
  end

  assign bclk_o = bclk_q;
  assign ws_o   = ws_q;
endmodule

// File: rtl/asrx_front.sv
module asrx_front #(
  parameter int unsigned N_PORTS = 2,
  parameter int unsigned STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(N_PORTS)-1:0] port_sel,
  input  logic                       master,
  input  logic                       gen_bclk,
  input  logic                       gen_ws,
  input  logic [N_PORTS-1:0]         bclk_in,
  input  logic [N_PORTS-1:0]         ws_in,
  input  logic [N_PORTS-1:0]         sd_in,
  output logic                       bit_stb,
  output logic                       ws_s,
  output logic                       sd_s
);
  import asrx_pkg::*;

  serial_t raw;
  serial_t chain_q [STAGES];
  logic    prev_bclk_q;

  always_comb begin
    raw.sd   = sd_in[port_sel];
    raw.bclk = master ? gen_bclk : bclk_in[port_sel];
    raw.ws   = master ? gen_ws   : ws_in[port_sel];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= (s == 0) ? raw : chain_q[(s == 0) ? 0 : s - 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_bclk_q <= 1'b0;
    else        prev_bclk_q <= chain_q[STAGES-1].bclk;
  end

  assign bit_stb = chain_q[STAGES-1].bclk & ~prev_bclk_q;
  assign ws_s    = chain_q[STAGES-1].ws;
  assign sd_s    = chain_q[STAGES-1].sd;
endmodule

// File: rtl/asrx_deframe.sv
module asrx_deframe #(
  parameter int unsigned CNT_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_stb,
  input  logic                        ws,
  input  logic                        sd,
  input  logic                        fmt_rj,
  input  logic                        alt,
  input  logic [1:0]                  res,
  output logic [asrx_pkg::OUT_W-1:0]  left_o,
  output logic [asrx_pkg::OUT_W-1:0]  right_o,
  output logic                        valid_o
);
  import asrx_pkg::*;

  localparam int unsigned HIST_W = OUT_W + 2;

  logic [NB_W-1:0]   nbits;
  logic [HIST_W-1:0] hist;
  logic [OUT_W-1:0]  rj_src, rj_word, word;
  logic [HIST_W-2:0] hist_q, hist_d;
  logic [OUT_W-1:0]  acc_q, acc_d, lhold_q, lhold_d;
  logic [OUT_W-1:0]  left_q, left_d, right_q, right_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ws_q, ws_d, locked_q, locked_d, hl_q, hl_d, valid_q, valid_d;
  logic              ws_edge;
  int                idx;

  always_comb begin
    nbits   = kept_bits(res);
    hist    = {hist_q, sd};
    rj_src  = alt ? hist[OUT_W+1:2] : hist[OUT_W:1];
    rj_word = rj_src << (OUT_W - nbits);
    ws_edge = bit_stb && (ws != ws_q);
    word    = fmt_rj ? rj_word : acc_q;
    idx     = int'(cnt_q) + 1 - (alt ? 0 : 1);
    hist_d  = hist_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    ws_d    = ws_q;
    locked_d = locked_q;
    hl_d    = hl_q;
    lhold_d = lhold_q;
    left_d  = left_q;
    right_d = right_q;
    valid_d = 1'b0;
    if (bit_stb) begin
      hist_d = hist[HIST_W-2:0];
      if (ws_edge) begin
        ws_d     = ws;
        locked_d = 1'b1;
        cnt_d    = '0;
        acc_d    = '0;
        if (alt) acc_d[OUT_W-1] = sd;
        if (locked_q) begin
          if (!ws_q) begin
            lhold_d = word;
            hl_d    = 1'b1;
          end else if (hl_q) begin
            left_d  = lhold_q;
            right_d = word;
            valid_d = 1'b1;
          end
        end
      end else begin
        if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
        if (cnt_q != '1 && idx >= 0 && idx < int'(nbits))
          acc_d[OUT_W-1-idx] = sd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      ws_q     <= 1'b0;
      locked_q <= 1'b0;
      hl_q     <= 1'b0;
      lhold_q  <= '0;
      left_q   <= '0;
      right_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (bit_stb) begin
        hist_q   <= hist_d;
        acc_q    <= acc_d;
        cnt_q    <= cnt_d;
        ws_q     <= ws_d;
        locked_q <= locked_d;
        hl_q     <= hl_d;
        lhold_q  <= lhold_d;
        left_q   <= left_d;
        right_q  <= right_d;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_LO      = 4,
  parameter int unsigned DIV_HI      = 6,
  parameter int unsigned FRAME_BITS  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_port_sel,
  input  logic        cfg_master,
  input  logic        cfg_mclk384,
  input  logic        cfg_rj,
  input  logic        cfg_alt,
  input  logic [1:0]  cfg_res,
  input  logic [1:0]  bclk_in,
  input  logic [1:0]  ws_in,
  input  logic [1:0]  sd_in,
  output logic        bclk_out,
  output logic        ws_out,
  output logic [19:0] left_out,
  output logic [19:0] right_out,
  output logic        sample_valid
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       gen_bclk, gen_ws, bit_stb, ws_s, sd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  asrx_clkgen #(
    .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .FRAME_BITS(FRAME_BITS)
  ) u_clkgen (
    .clk(clk), .rst_n(rst_core_n), .en(cfg_master), .sel_hi(cfg_mclk384),
    .bclk_o(gen_bclk), .ws_o(gen_ws)
  );

  asrx_front #(.N_PORTS(2), .STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_core_n), .port_sel(cfg_port_sel), .master(cfg_master),
    .gen_bclk(gen_bclk), .gen_ws(gen_ws), .bclk_in(bclk_in), .ws_in(ws_in),
    .sd_in(sd_in), .bit_stb(bit_stb), .ws_s(ws_s), .sd_s(sd_s)
  );

  asrx_deframe #(.CNT_W($clog2(FRAME_BITS))) u_deframe (
    .clk(clk), .rst_n(rst_core_n), .bit_stb(bit_stb), .ws(ws_s), .sd(sd_s),
    .fmt_rj(cfg_rj), .alt(cfg_alt), .res(cfg_res),
    .left_o(left_out), .right_o(right_out), .valid_o(sample_valid)
  );

  assign bclk_out = gen_bclk;
  assign ws_out   = gen_ws;
endmodule

// File: rtl/asrx_chk.sv
module asrx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_master,
  input logic [1:0]  cfg_res,
  input logic        bclk_out,
  input logic        ws_out,
  input logic [19:0] left_out,
  input logic [19:0] right_out,
  input logic        sample_valid
);
  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R10
  bclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $rose(bclk_out) |=> bclk_out);

  // R10
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $past(cfg_master) && !$stable(ws_out) |-> $fell(bclk_out));

  // R5
  pad16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && cfg_res == 2'd0 |-> left_out[3:0] == 4'd0 && right_out[3:0] == 4'd0);

  // R11
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master && !$past(cfg_master) |-> !bclk_out && !ws_out);
endmodule

bind audio_serial_rx asrx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_res(cfg_res),
  .bclk_out(bclk_out), .ws_out(ws_out), .left_out(left_out),
  .right_out(right_out), .sample_valid(sample_valid)
);

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        cfg_port_sel, cfg_master, cfg_mclk384, cfg_rj, cfg_alt;
  logic [1:0]  cfg_res;
  logic [1:0]  bclk_in, ws_in, sd_in;
  logic        bclk_out, ws_out, sample_valid;
  logic [19:0] left_out, right_out;

  audio_serial_rx i_audio_serial_rx (.*);

  int checks = 0, failures = 0;
  string cur_tag = "R2";
  logic [23:0] lw [16];
  logic [23:0] rw [16];
  int tx_bits = 16, shift_s = 0, nval = 0, ncyc = 0;
  logic noise_en = 1'b0;

  typedef struct { int cyc; logic [19:0] l; logic [19:0] r; } exp_t;
  exp_t exp_q [$];
  logic m_pb, m_pws, m_locked, m_hl;
  logic [19:0] m_left;
  logic m_slot [$];
  int last_rise, rises_since_ws;
  logic m_pwso;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic data_bit(input int d);
    int f, ch, p;
    logic [23:0] w;
    if (d < 0) return 1'b0;
    f = (d / 64) % 16; ch = (d % 64) / 32; p = d % 32;
    w = ch ? rw[f] : lw[f];
    if (!cfg_rj) return (p < tx_bits) ? w[tx_bits-1-p] : 1'b0;
    return (p >= 32 - tx_bits) ? w[31-p] : 1'b0;
  endfunction

  function automatic int eff_n();
    return (cfg_res == 2'd0) ? 16 : (cfg_res == 2'd1) ? 18 : 20;
  endfunction

  function automatic logic slot_at(input int i);
    if (i < 0 || i >= m_slot.size()) return 1'b0;
    return m_slot[i];
  endfunction

  function automatic logic [19:0] model_word(input logic cur);
    logic [19:0] w = '0;
    int n = eff_n();
    int l = m_slot.size();
    int b;
    for (int i = 0; i < n; i++) begin
      if (!cfg_rj) b = cfg_alt ? slot_at(i) : slot_at(i + 1);
      else         b = cfg_alt ? slot_at(l - n - 1 + i) : slot_at(l - n + i);
      w[19-i] = b[0];
    end
    if (cur === 1'bx) w = '0;
    return w;
  endfunction

  // reference model, sampled on the falling clock edge
  always @(negedge clk) begin
    logic b, w, s;
    logic [19:0] wd;
    ncyc++;
    if (!rst_n) begin
      exp_q.delete(); m_slot.delete();
      m_pb = 0; m_pws = 0; m_locked = 0; m_hl = 0; m_left = '0;
      last_rise = -1; rises_since_ws = 0; m_pwso = 0;
    end else begin
      b = cfg_master ? bclk_out : bclk_in[cfg_port_sel];
      w = cfg_master ? ws_out   : ws_in[cfg_port_sel];
      s = sd_in[cfg_port_sel];
      if (exp_q.size() > 0 && exp_q[0].cyc == ncyc) begin
        chk(sample_valid === 1'b1, {cur_tag, " R7 R9 pulse"}, 64'(sample_valid), 64'd1);
        chk(left_out === exp_q[0].l, {cur_tag, " R5 left"}, 64'(left_out), 64'(exp_q[0].l));
        chk(right_out === exp_q[0].r, {cur_tag, " R5 right"}, 64'(right_out), 64'(exp_q[0].r));
        void'(exp_q.pop_front());
        nval++;
      end else begin
        chk(sample_valid === 1'b0, {cur_tag, " R8 R9 no pulse"}, 64'(sample_valid), 64'd0);
      end
      if (!cfg_master)
        chk(bclk_out === 1'b0 && ws_out === 1'b0, "R11 idle clocks", 64'({bclk_out, ws_out}), 64'd0);
      else begin
        if (bclk_out && !m_pb) begin
          if (last_rise >= 0)
            chk(ncyc - last_rise == (cfg_mclk384 ? 6 : 4), "R10 bclk period",
                64'(ncyc - last_rise), cfg_mclk384 ? 64'd6 : 64'd4);
          last_rise = ncyc;
          rises_since_ws++;
        end
        if (ws_out !== m_pwso) begin
          chk(rises_since_ws == 32, "R10 ws spacing", 64'(rises_since_ws), 64'd32);
          rises_since_ws = 0;
        end
        m_pwso = ws_out;
      end
      if (b && !m_pb) begin
        if (w != m_pws) begin
          wd = model_word(s);
          if (m_locked) begin
            if (!m_pws) begin m_left = wd; m_hl = 1; end
            else if (m_hl) exp_q.push_back('{ncyc + 3, m_left, wd});
          end
          m_locked = 1; m_pws = w;
          m_slot.delete();
        end
        m_slot.push_back(s);
        if (m_slot.size() > 64) void'(m_slot.pop_front());
      end
      m_pb = b;
    end
  end

  // activity on the port that is not selected
  always @(posedge clk) begin
    #1;
    if (noise_en) begin
      bclk_in[~cfg_port_sel] = 1'($urandom);
      ws_in[~cfg_port_sel]   = 1'($urandom);
      sd_in[~cfg_port_sel]   = 1'($urandom);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setup(input logic sel, input logic mst, input logic m384, input logic rj,
                       input logic alt, input logic [1:0] res, input int bits, input string tag);
    @(posedge clk); #1;
    rst_n = 0; noise_en = 0;
    cfg_port_sel = sel; cfg_master = mst; cfg_mclk384 = m384;
    cfg_rj = rj; cfg_alt = alt; cfg_res = res; tx_bits = bits; cur_tag = tag;
    bclk_in = '0; ws_in = '0; sd_in = '0;
    shift_s = rj ? (alt ? 1 : 0) : (alt ? 0 : -1);
    for (int i = 0; i < 16; i++) begin lw[i] = 24'($urandom); rw[i] = 24'($urandom); end
    sd_in[sel] = data_bit(shift_s);
    tick(3);
    // R8 reset state
    chk(left_out == 0 && right_out == 0 && sample_valid == 0, "R8 reset outputs",
        64'({left_out, right_out, sample_valid}), 64'd0);
    nval = 0;
    rst_n = 1;
  endtask

  task automatic run_slave(input int frames, input int half);
    tick(10);
    for (int w = 0; w < frames * 64; w++) begin
      bclk_in[cfg_port_sel] = 0;
      ws_in[cfg_port_sel]   = 1'((w / 32) % 2);
      sd_in[cfg_port_sel]   = data_bit(w + shift_s);
      tick(half);
      bclk_in[cfg_port_sel] = 1;
      tick(half);
    end
    tick(12);
  endtask

  task automatic run_master(input int frames);
    int j = 0;
    logic pb = 0;
    while (j < frames * 64) begin
      tick(1);
      if (pb && !bclk_out) begin
        j++;
        sd_in[cfg_port_sel] = data_bit(j + shift_s);
      end
      pb = bclk_out;
    end
    tick(12);
  endtask

  task automatic frames_seen(input int want, input string tag);
    chk(nval >= want && exp_q.size() == 0, {tag, " R7 frame count"}, 64'(nval), 64'(want));
  endtask

  initial begin
    rst_n = 0;
    cfg_port_sel = 0; cfg_master = 0; cfg_mclk384 = 0; cfg_rj = 0; cfg_alt = 0; cfg_res = 0;
    bclk_in = '0; ws_in = '0; sd_in = '0;
    // R2 R5: normal MSB-first, 16 bits
    setup(0, 0, 0, 0, 0, 2'd0, 16, "R2"); run_slave(5, 4); frames_seen(3, "R2");
    // R1 R3 R6: alternative MSB-first, 24 bits, noise on port 0
    setup(1, 0, 0, 0, 1, 2'd3, 24, "R3 R6 R1"); noise_en = 1; run_slave(5, 4);
    noise_en = 0; frames_seen(3, "R3");
    // R4 R1: normal end-aligned, 18 bits, noise on port 1
    setup(0, 0, 0, 1, 0, 2'd1, 18, "R4 R1"); noise_en = 1; run_slave(5, 3);
    noise_en = 0; frames_seen(3, "R4");
    // R3: alternative end-aligned, 20 bits
    setup(1, 0, 0, 1, 1, 2'd2, 20, "R3"); run_slave(5, 4); frames_seen(3, "R3");
    // R6: end-aligned with code 3 handled as 20 bits
    setup(0, 0, 0, 1, 0, 2'd3, 20, "R6"); run_slave(4, 4); frames_seen(2, "R6");
    // R2: normal MSB-first, 18 bits, faster bit clock
    setup(1, 0, 0, 0, 0, 2'd1, 18, "R2"); run_slave(4, 2); frames_seen(2, "R2");
    // R10 R12: master /4, MSB-first normal, 20 bits
    setup(1, 1, 0, 0, 0, 2'd2, 20, "R12 R10"); run_master(6); frames_seen(4, "R12");
    // R10 R12 R3: master /6, end-aligned alternative, 16 bits
    setup(0, 1, 1, 1, 1, 2'd0, 16, "R12 R3"); run_master(6); frames_seen(4, "R12");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule